// File: doc/BRIEF.md
# Converter Bring-Up and Sample Acquisition Sequencer

This block is the host side of a serial link to a sigma-delta converter. One pulse on `start` runs a fixed bring-up script over a four-wire serial link (clock idle high, data launched on the falling edge and captured on the rising edge, most significant bit first). The script has two chip-select frames. The first frame sets up the converter clock: the master clock is divided by two and the output update rate is 50 Hz. The second frame programs the analog setup and starts a self-calibration. Every command byte addresses the first input channel.

After the setup the sequencer collects a programmed number of 16-bit conversion results. Before each read it waits for the converter to report ready. In pin mode it watches the active-low ready pin through a two-flop synchroniser. In poll mode it ignores that pin and reads the converter's command register, testing the ready flag in that register. Each result is handed out for one cycle with a strobe. A `done` pulse marks the end of the batch. If the converter stays not-ready too long, the run stops and the `err` flag is raised.

The serial clock half-period is derived from the system clock so that the link never runs faster than `SCLK_MAX_HZ`. Chip select is low only during a frame, and the line returns high for at least one half-period between frames.

Top module: `adc_bringup_seq`

## Requirements
- R1: After reset, and whenever the sequencer is idle, `cs_n` and `sclk` are 1, and `out_valid`, `done` and `err` are 0.
- R2: `sclk` is 1 whenever `cs_n` is 1. Every high or low phase of `sclk` lasts at least HALF = ceil(CLK_HZ / (2*SCLK_MAX_HZ)) system clocks. `mosi` changes only on falling edges, and `miso` is captured on rising edges, most significant bit first.
- R3: An accepted `start` first sends one 16-bit frame holding 0x20 and then 0x0C. In 0x20, bits 6:4 = 010 select the clock register, bit 3 = 0 means write, and bits 1:0 = 00 select channel 1. In 0x0C, bit 3 divides the master clock by two, bit 2 selects the 4.9152 MHz crystal setting, and bits 1:0 = 00 select a 50 Hz update rate.
- R4: The second frame is 16 bits holding 0x10 and then 0x40. In 0x10, bits 6:4 = 001 select the setup register, with write and channel 1. In 0x40, bits 7:6 = 01 start a self-calibration, bits 5:3 = 000 select gain 1, bit 2 = 0 selects bipolar coding, bit 1 = 0 turns the buffer off, and bit 0 = 0 clears filter sync.
- R5: In pin mode (USE_DRDY_PIN = 1) the sequencer waits for the synchronised `drdy_n` to be 0. It then sends one 24-clock frame: command 0x38 (bits 6:4 = 011 data register, bit 3 = 1 read, channel 1), followed by 16 received bits. No poll frames are sent.
- R6: In poll mode (USE_DRDY_PIN = 0) the `drdy_n` pin has no effect. The sequencer sends 16-bit frames holding command 0x08 (a read of the command register) and tests bit 7 of the received byte. A 0 there means ready and leads to a data read frame; a 1 leads to another poll.
- R7: Each data read produces one cycle of `out_valid`, with `out_data` equal to the 16 received bits, in a cycle when `cs_n` is already 1.
- R8: After SAMPLES results, `done` is 1 for exactly one cycle, in the cycle right after the last `out_valid`. The sequencer then goes idle.
- R9: A `start` pulse that arrives while a run is in progress is ignored: no extra configuration frames are sent and the sample count is not changed.
- R10: If ready is not seen within TIMEOUT_CYC cycles of entering a wait, `err` is set and the sequencer goes idle with no further frames, `out_valid` or `done`. `err` holds until the next accepted `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up and acquisition run (accepted only when idle) |
| drdy_n | input | 1 | Converter ready pin, active low, asynchronous |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idle high |
| cs_n | output | 1 | Chip select, active low, one assertion per frame |
| mosi | output | 1 | Serial data to the converter |
| out_valid | output | 1 | One-cycle strobe for a new sample |
| out_data | output | 16 | Sample value, valid with `out_valid` |
| done | output | 1 | One-cycle pulse after the final sample |
| err | output | 1 | Ready timeout flag |

## Verification
The assertions check the link timing on every cycle: the clock idles high outside frames, and no clock phase is shorter than the derived half-period. They also check three ordering rules: samples appear only after their frame has closed, `done` comes only right after a sample, and an error arrives with the bus released and without results. The byte contents of the configuration frames, the command choice between pin and poll modes, the sample values, the ignoring of a second start, and recovery after a timeout all depend on a converter model and on whole runs. Only the bench scenarios show those behaviours.

// File: rtl/adc_bringup_seq.sv
module adc_bringup_seq #(
  parameter int CLK_HZ       = 50_000_000,
  parameter int SCLK_MAX_HZ  = 3_000_000,
  parameter int SAMPLES      = 1000,
  parameter int TIMEOUT_CYC  = 10_000_000,
  parameter bit USE_DRDY_PIN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        drdy_n,
  input  logic        miso,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  output logic        out_valid,
  output logic [15:0] out_data,
  output logic        done,
  output logic        err
);
  localparam int HALF = (CLK_HZ + 2*SCLK_MAX_HZ - 1) / (2*SCLK_MAX_HZ);
  localparam int DW   = $clog2(HALF + 1);
  localparam int CW   = $clog2(SAMPLES + 1);
  localparam int TW   = $clog2(TIMEOUT_CYC + 1) + 1;
  localparam logic [DW-1:0] DLIM = DW'(HALF - 1);
  localparam logic [CW-1:0] SLIM = CW'(SAMPLES - 1);
  localparam logic [TW-1:0] TLIM = TW'(TIMEOUT_CYC);

  localparam logic [7:0] CMD_CLK  = 8'h20;
  localparam logic [7:0] CLK_CFG  = 8'h0C;
  localparam logic [7:0] CMD_SET  = 8'h10;
  localparam logic [7:0] SET_CFG  = 8'h40;
  localparam logic [7:0] CMD_RD   = 8'h38;
  localparam logic [7:0] CMD_POLL = 8'h08;

  typedef enum logic [2:0] {IDLE, CFG_CLK, CFG_SET, WAIT_RDY, POLL, READ, FIN} st_t;
  st_t st, nxt;

  logic          act, tail;
  logic [DW-1:0] div;
  logic [4:0]    nb, bc;
  logic [23:0]   tx;
  logic [15:0]   rx;
  logic [1:0]    dsync;
  logic [CW-1:0] nsmp;
  logic [TW-1:0] tmr;

  logic          go, set_err;
  logic [23:0]   go_tx;
  logic [4:0]    go_nb;

  wire tick     = act && (div == DLIM);
  wire xfer_end = tick && tail;
  wire rdy_pin  = ~dsync[1];
  assign mosi   = tx[23];

  always_comb begin
    go      = 1'b0;
    go_tx   = '0;
    go_nb   = 5'd16;
    set_err = 1'b0;
    nxt     = st;
    case (st)
      IDLE:    if (start) begin go = 1'b1; go_tx = {CMD_CLK, CLK_CFG, 8'h00}; nxt = CFG_CLK; end
      CFG_CLK: if (xfer_end) begin go = 1'b1; go_tx = {CMD_SET, SET_CFG, 8'h00}; nxt = CFG_SET; end
      CFG_SET: if (xfer_end) nxt = WAIT_RDY;
      WAIT_RDY: begin
        if (USE_DRDY_PIN && rdy_pin) begin
          go = 1'b1; go_tx = {CMD_RD, 16'h0000}; go_nb = 5'd24; nxt = READ;
        end else if (tmr >= TLIM) begin
          set_err = 1'b1; nxt = IDLE;
        end else if (!USE_DRDY_PIN) begin
          go = 1'b1; go_tx = {CMD_POLL, 16'h0000}; nxt = POLL;
        end
      end
      POLL: if (xfer_end) begin
        if (!rx[7]) begin go = 1'b1; go_tx = {CMD_RD, 16'h0000}; go_nb = 5'd24; nxt = READ; end
        else nxt = WAIT_RDY;
      end
      READ:    if (xfer_end) nxt = (nsmp == SLIM) ? FIN : WAIT_RDY;
      FIN:     nxt = IDLE;
      default: nxt = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; act <= 1'b0; tail <= 1'b0; div <= '0; nb <= 5'd16; bc <= '0;
      tx <= '0; rx <= '0; dsync <= 2'b11; nsmp <= '0; tmr <= '0;
      sclk <= 1'b1; cs_n <= 1'b1; out_valid <= 1'b0; out_data <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      st        <= nxt;
      dsync     <= {dsync[0], drdy_n};
      out_valid <= 1'b0;
      done      <= (st == FIN);

      if (act) div <= tick ? '0 : div + 1'b1;
      if (tick) begin
        if (tail) act <= 1'b0;
        else if (sclk) begin
          if (bc == nb) begin cs_n <= 1'b1; tail <= 1'b1; end
          else begin
            sclk <= 1'b0;
            if (bc != 0) tx <= {tx[22:0], 1'b0};
          end
        end else begin
          sclk <= 1'b1;
          rx   <= {rx[14:0], miso};
          bc   <= bc + 1'b1;
        end
      end
      if (go) begin
        act <= 1'b1; tail <= 1'b0; div <= '0; bc <= '0;
        cs_n <= 1'b0; sclk <= 1'b1; tx <= go_tx; nb <= go_nb;
      end

      if ((st == CFG_SET || st == READ) && nxt == WAIT_RDY) tmr <= '0;
      else if ((st == WAIT_RDY || st == POLL) && tmr != '1) tmr <= tmr + 1'b1;

      if (st == IDLE && start) begin err <= 1'b0; nsmp <= '0; end
      if (set_err) err <= 1'b1;
      if (st == READ && xfer_end) begin
        out_valid <= 1'b1;
        out_data  <= rx;
        nsmp      <= nsmp + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_bringup_seq_chk.sv
module adc_bringup_seq_chk #(
  parameter int HALF = 2
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic cs_n,
  input logic out_valid,
  input logic done,
  input logic err
);
  logic sclk_q;
  int   run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      run    <= HALF;
    end else begin
      sclk_q <= sclk;
      if (sclk != sclk_q) run <= 0;
      else if (run < HALF) run <= run + 1;
    end
  end

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> sclk);
  // R2
  sclk_half_chk: assert property (@(posedge clk) disable iff (!rst_n) (sclk != sclk_q) |-> (run >= HALF - 1));
  // R7
  valid_closed_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> cs_n);
  // R8
  done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(out_valid));
  // R10
  err_released_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> cs_n);
  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> (!out_valid && !done));
endmodule

bind adc_bringup_seq adc_bringup_seq_chk #(.HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
  .out_valid(out_valid), .done(done), .err(err)
);

// File: tb/tb_adc_bringup_seq.sv
`timescale 1ns/1ps
module tb_adc_model (
  input  logic        clk,
  input  logic        clr,
  input  logic        stall,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  input  logic [15:0] word,
  output logic        miso,
  output logic        drdy_n,
  output logic [31:0] wlog,
  output int          wcnt,
  output int          rdcnt,
  output int          pcnt,
  output int          bad,
  output int          idx
);
  logic ready = 1'b0;
  logic ps = 1'b1, pc = 1'b1;
  logic [7:0] sh = '0, cmd = '0;
  logic [15:0] dout = '0;
  int bi = 0, dly = 0;
  initial begin miso = 1'b1; wlog = '0; wcnt = 0; rdcnt = 0; pcnt = 0; bad = 0; idx = 0; end
  assign drdy_n = ~ready;

  always @(posedge clk) begin
    ps <= sclk; pc <= cs_n;
    if (clr) begin wcnt <= 0; rdcnt <= 0; pcnt <= 0; bad <= 0; wlog <= '0; end
    if (!ready && !stall) begin dly = dly + 1; if (dly >= 300) ready <= 1'b1; end
    if (pc && !cs_n) bi = 0;
    if (!cs_n && !ps && sclk) begin
      sh = {sh[6:0], mosi};
      bi = bi + 1;
      if (bi == 8) begin
        cmd = sh;
        case (cmd)
          8'h38: dout = word;
          8'h08: dout = {~ready, 15'h0000};
          8'h20, 8'h10: dout = '0;
          default: begin dout = '0; bad <= bad + 1; end
        endcase
      end
      if (bi == 16 && (cmd == 8'h20 || cmd == 8'h10)) begin
        wlog <= {wlog[15:0], cmd, sh};
        wcnt <= wcnt + 1;
        if (cmd == 8'h10) begin ready <= 1'b0; dly = 0; idx <= 0; end
      end
      if (bi == 16 && cmd == 8'h08) pcnt <= pcnt + 1;
      if (bi == 24 && cmd == 8'h38) begin rdcnt <= rdcnt + 1; ready <= 1'b0; dly = 0; idx <= idx + 1; end
    end
    if (!cs_n && ps && !sclk && bi >= 8) begin
      miso <= dout[15];
      dout = {dout[14:0], 1'b0};
    end
  end
endmodule

module tb_adc_bringup_seq;
  localparam int NS = 5;
  localparam logic [15:0] SAMP [NS] = '{16'h8000, 16'h7FFF, 16'h0001, 16'hFFFE, 16'hA55A};
  localparam logic [31:0] CFG_WORDS = 32'h200C_1040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] start = '0, stall = '0, clr = '0;
  logic [1:0] sclk, cs_n, mosi, miso, drdy_m, pin, ov, done, err;
  logic [15:0] od [2];
  logic [15:0] word [2];
  logic [31:0] wlog [2];
  int wcnt [2], rdcnt [2], pcnt [2], bad [2], midx [2];
  logic [15:0] cap [2][8];
  int ncap [2], ndone [2], viol [2], gapc [2];
  logic ps [2], pv [2];

  int nchk = 0, nfail = 0;
  bit finished = 0;

  for (genvar g = 0; g < 2; g++) begin : g_dut
    assign word[g] = SAMP[midx[g] % NS];
    assign pin[g]  = (g == 0) ? drdy_m[g] : 1'b0;

    adc_bringup_seq #(
      .CLK_HZ(24_000_000), .SCLK_MAX_HZ(3_000_000), .SAMPLES(NS),
      .TIMEOUT_CYC(1500), .USE_DRDY_PIN((g == 0) ? 1'b1 : 1'b0)
    ) dut (
      .clk(clk), .rst_n(rst_n), .start(start[g]), .drdy_n(pin[g]), .miso(miso[g]),
      .sclk(sclk[g]), .cs_n(cs_n[g]), .mosi(mosi[g]), .out_valid(ov[g]),
      .out_data(od[g]), .done(done[g]), .err(err[g])
    );

    tb_adc_model model (
      .clk(clk), .clr(clr[g]), .stall(stall[g]), .sclk(sclk[g]), .cs_n(cs_n[g]),
      .mosi(mosi[g]), .word(word[g]), .miso(miso[g]), .drdy_n(drdy_m[g]),
      .wlog(wlog[g]), .wcnt(wcnt[g]), .rdcnt(rdcnt[g]), .pcnt(pcnt[g]),
      .bad(bad[g]), .idx(midx[g])
    );

    always @(negedge clk) begin
      if (rst_n) begin
        if (ov[g]) begin
          if (ncap[g] < 8) cap[g][ncap[g]] = od[g];
          ncap[g] = ncap[g] + 1;
        end
        if (done[g]) begin
          ndone[g] = ndone[g] + 1;
          if (!pv[g]) viol[g] = viol[g] + 1;
        end
        if (cs_n[g] && !sclk[g]) viol[g] = viol[g] + 1;
        if (ov[g] && !cs_n[g]) viol[g] = viol[g] + 1;
        if (sclk[g] != ps[g]) begin
          if (!cs_n[g] && gapc[g] < 4) viol[g] = viol[g] + 1;
          gapc[g] = 1;
        end else gapc[g] = gapc[g] + 1;
      end
      ps[g] = sclk[g];
      pv[g] = ov[g];
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear(input int k);
    @(posedge clk);
    ncap[k] = 0; ndone[k] = 0; viol[k] = 0;
    clr[k] = 1'b1;
    @(posedge clk);
    clr[k] = 1'b0;
  endtask

  task automatic pulse_start(input int k);
    @(negedge clk); start[k] = 1'b1;
    @(negedge clk); start[k] = 1'b0;
  endtask

  task automatic wait_end(input int k, input string req);
    bit seen = 0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (ndone[k] > 0 || err[k]) begin seen = 1; break; end
    end
    chk(seen, req, "run did not finish", 0, 1);
  endtask

  task automatic normal_run(input int k);
    string mode;
    mode = (k == 0) ? "pin" : "poll";
    clear(k);
    pulse_start(k);
    for (int c = 0; c < 20000 && ncap[k] < 1; c++) @(negedge clk);
    pulse_start(k);  // R9: second start while busy
    wait_end(k, "R8");
    repeat (20) @(negedge clk);
    chk(wlog[k][31:16] == CFG_WORDS[31:16], "R3", {mode, " clock frame"}, wlog[k][31:16], CFG_WORDS[31:16]);
    chk(wlog[k][15:0] == CFG_WORDS[15:0], "R4", {mode, " setup frame"}, wlog[k][15:0], CFG_WORDS[15:0]);
    chk(wcnt[k] == 2, "R9", {mode, " config frames after extra start"}, wcnt[k], 2);
    chk(ncap[k] == NS, "R8", {mode, " sample count"}, ncap[k], NS);
    for (int i = 0; i < NS; i++)
      chk(cap[k][i] == SAMP[i], "R7", {mode, " sample value"}, cap[k][i], SAMP[i]);
    chk(ndone[k] == 1, "R8", {mode, " done pulses"}, ndone[k], 1);
    chk(viol[k] == 0, "R2", {mode, " serial timing violations"}, viol[k], 0);
    chk(bad[k] == 0, "R5", {mode, " unknown commands"}, bad[k], 0);
    chk(rdcnt[k] == NS, "R5", {mode, " data read frames"}, rdcnt[k], NS);
    if (k == 0) chk(pcnt[k] == 0, "R5", "pin mode poll frames", pcnt[k], 0);
    else        chk(pcnt[k] > 0, "R6", "poll mode poll frames", pcnt[k], 1);
    chk(cs_n[k] && sclk[k] && !err[k], "R1", {mode, " idle after run"}, {cs_n[k], sclk[k], err[k]}, 3'b110);
  endtask

  task automatic timeout_run(input int k);
    clear(k);
    stall[k] = 1'b1;
    pulse_start(k);
    wait_end(k, "R10");
    repeat (40) @(negedge clk);
    chk(err[k] == 1'b1, "R10", "err after stall", err[k], 1);
    chk(ncap[k] == 0 && ndone[k] == 0, "R10", "no output on timeout", ncap[k] + ndone[k], 0);
    chk(cs_n[k] == 1'b1 && rdcnt[k] == 0, "R10", "bus released, no read", rdcnt[k], 0);
    stall[k] = 1'b0;
    clear(k);
    pulse_start(k);
    @(negedge clk);
    chk(err[k] == 1'b0, "R10", "err cleared by start", err[k], 0);
    wait_end(k, "R10");
    repeat (20) @(negedge clk);
    chk(ncap[k] == NS && err[k] == 1'b0, "R10", "recovery run samples", ncap[k], NS);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      ncap[k] = 0; ndone[k] = 0; viol[k] = 0; gapc[k] = 0; ps[k] = 1'b1; pv[k] = 1'b0;
    end
    repeat (5) @(negedge clk);
    for (int k = 0; k < 2; k++)
      chk(cs_n[k] && sclk[k] && !ov[k] && !done[k] && !err[k], "R1", "reset state",
          {cs_n[k], sclk[k], ov[k], done[k], err[k]}, 5'b11000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    normal_run(0);
    normal_run(1);
    timeout_run(0);
    timeout_run(1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule